// File: doc/BRIEF.md
# Multi-source interrupt controller

This block collects interrupt requests from five sources and presents one service request, with a vector address, to a small processor core. The sources are an external pin, two timer/event counters, a serial port (UART) and an analog-to-digital converter. Each source has a request flag and an enable bit. A global master enable gates every source. All of these bits sit in two byte-wide control registers that software reads and writes through a simple select/write port.

The core acknowledges a request by pulsing `irq_ack` while `irq_req` is high. On that edge the block clears the served source's flag and drops the master enable, so a second interrupt cannot nest unless the handler sets the master enable again. The core signals a return-with-enable on `reti_en`, which restores the master enable. While the core reports a full call stack, no request is offered at all. The external pin passes through two synchronising flip-flops and an edge detector, which can be set to rising, falling or both edges. Any set flag drives a wake-up output.

Top module: `irq_ctrl`

## Requirements
- R1: When several enabled sources are pending, the winner follows the fixed priority external (index 0), timer 0 (1), timer 1 (2), UART (3), ADC (4). `irq_vec` shows VEC_BASE + VEC_STEP*index of the winner (defaults 4 and 4, so 0x04, 0x08, 0x0C, 0x10, 0x14). It reads 0 when no enabled source is pending.
- R2: Control register A (`reg_sel`=0) holds the master enable at bit 0, the enables of sources 0..2 at bits 1..3 and their flags at bits 4..6. Bit 7 ignores writes and reads 0.
- R3: Control register B (`reg_sel`=1) holds the enables of sources 3..4 at bits 0..1 and their flags at bits 4..5. Bits 2, 3, 6 and 7 ignore writes and read 0. `reg_rdata` shows the selected register in the same cycle.
- R4: `irq_req` is high exactly when the master enable is set, at least one source has both its flag and its enable set, and `stack_full` is low.
- R5: While `stack_full` is high no request is offered, and an `irq_ack` in that cycle changes no state.
- R6: An acknowledge (`irq_ack` high while `irq_req` is high) clears the master enable and the winning source's flag at the next clock edge.
- R7: A source event sets its flag whether or not the master enable or its own enable is set. The flag stays pending until it is served or written to 0.
- R8: Software may set the master enable after an acknowledge, through register A, to let a later request nest.
- R9: A `reti_en` pulse sets the master enable at the next edge.
- R10: The external pin goes through two synchronising flip-flops. A rising edge counts when `ext_rise_en` is set and a falling edge counts when `ext_fall_en` is set. A level present before edge k sets the flag at edge k+2 after the edge detector sees it, so the flag is visible after the third clock edge.
- R11: `wake` is high whenever any flag is set, regardless of the enables.
- R12: Within one edge, updates apply in this order: register write, then `reti_en`, then acknowledge clear, then new source events. An event therefore wins over a write of 0 or an acknowledge of its own flag.
- R13: After reset, all enables, flags and the master enable are 0, so `irq_req`, `wake` and `irq_vec` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| ext_rise_en | input | 1 | Count rising edges of the pin |
| ext_fall_en | input | 1 | Count falling edges of the pin |
| periph_req | input | 4 | Event pulses: bit 0 timer 0, bit 1 timer 1, bit 2 UART, bit 3 ADC |
| reg_we | input | 1 | Write strobe for the selected control register |
| reg_sel | input | 1 | Register select: 0 register A, 1 register B |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| stack_full | input | 1 | Core call stack is full |
| irq_ack | input | 1 | Core accepts the offered request |
| reti_en | input | 1 | Return from handler with master enable set |
| irq_req | output | 1 | Service request toward the core |
| irq_vec | output | VEC_W | Vector address of the winning source |
| wake | output | 1 | Wake-up: some request flag is set |

## Verification
The assertions assume that every input except `ext_pin` is synchronous to `clk` and two-valued after reset. They also assume that `irq_ack` only matters in a cycle where `irq_req` is high. The flag-clearing property is limited to cycles with no register write and no new event, since R12 lets those override the clear. The bench changes every input, the pin included, only at falling edges. Its random phase freely mixes acknowledges, returns, writes and a full stack, including acknowledges that arrive while no request is offered.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC    = 5;
  localparam int A_SLOTS = 3;
  localparam int B_SLOTS = NSRC - A_SLOTS;
  localparam int REG_W   = 8;
  localparam int EN_LSB_A = 1;
  localparam int EN_LSB_B = 0;
  localparam int FLAG_LSB = 4;

  typedef enum logic {
    SEL_A = 1'b0,
    SEL_B = 1'b1
  } reg_sel_e;

  // vector address of a source index
  function automatic int vector_at(input int base, input int step, input int idx);
    return base + step * idx;
  endfunction
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_en,
  input  logic fall_en,
  output logic edge_evt
);
  localparam int LAST = SYNC_STAGES;

  // chain[0..SYNC_STAGES-1] synchronise, chain[LAST] keeps the previous level
  logic [LAST:0] chain;
  logic cur_lvl, prev_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[LAST-1:0], pin};
  end

  assign cur_lvl  = chain[LAST-1];
  assign prev_lvl = chain[LAST];
  assign edge_evt = (cur_lvl & ~prev_lvl & rise_en) | (~cur_lvl & prev_lvl & fall_en);
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             sel,
  input  logic [REG_W-1:0] wdata,
  input  logic [NSRC-1:0]  evt,
  input  logic             take,
  input  logic [NSRC-1:0]  grant,
  input  logic             reti_en,
  output logic [NSRC-1:0]  en,
  output logic [NSRC-1:0]  flag,
  output logic             master,
  output logic [REG_W-1:0] rdata
);
  logic [NSRC-1:0] en_n, flag_n;
  logic            master_n;
  logic            hit_a, hit_b;

  assign hit_a = we && (sel == SEL_A);
  assign hit_b = we && (sel == SEL_B);

  // precedence: write, return-with-enable, acknowledge clear, new events
  always_comb begin
    en_n     = en;
    flag_n   = flag;
    master_n = master;
    if (hit_a) begin
      master_n = wdata[0];
      for (int i = 0; i < A_SLOTS; i++) begin
        en_n[i]   = wdata[EN_LSB_A + i];
        flag_n[i] = wdata[FLAG_LSB + i];
      end
    end
    if (hit_b) begin
      for (int i = 0; i < B_SLOTS; i++) begin
        en_n[A_SLOTS + i]   = wdata[EN_LSB_B + i];
        flag_n[A_SLOTS + i] = wdata[FLAG_LSB + i];
      end
    end
    if (reti_en) master_n = 1'b1;
    if (take) begin
      master_n = 1'b0;
      flag_n   = flag_n & ~grant;
    end
    flag_n = flag_n | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= '0;
      flag   <= '0;
      master <= 1'b0;
    end else begin
      en     <= en_n;
      flag   <= flag_n;
      master <= master_n;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel == SEL_A) begin
      rdata[0] = master;
      for (int i = 0; i < A_SLOTS; i++) begin
        rdata[EN_LSB_A + i] = en[i];
        rdata[FLAG_LSB + i] = flag[i];
      end
    end else begin
      for (int i = 0; i < B_SLOTS; i++) begin
        rdata[EN_LSB_B + i] = en[A_SLOTS + i];
        rdata[FLAG_LSB + i] = flag[A_SLOTS + i];
      end
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input  logic [NSRC-1:0]  pend,
  output logic [NSRC-1:0]  grant,
  output logic [VEC_W-1:0] vec
);
  logic found;

  // lowest index has the highest priority
  always_comb begin
    grant = '0;
    vec   = '0;
    found = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && !found) begin
        grant[i] = 1'b1;
        vec      = VEC_W'(vector_at(VEC_BASE, VEC_STEP, i));
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int VEC_W       = 8,
  parameter int VEC_BASE    = 4,
  parameter int VEC_STEP    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_pin,
  input  logic               ext_rise_en,
  input  logic               ext_fall_en,
  input  logic [NSRC-2:0]    periph_req,
  input  logic               reg_we,
  input  logic               reg_sel,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic               stack_full,
  input  logic               irq_ack,
  input  logic               reti_en,
  output logic               irq_req,
  output logic [VEC_W-1:0]   irq_vec,
  output logic               wake
);
  logic            ext_evt;
  logic [NSRC-1:0] evt_vec;
  logic [NSRC-1:0] en, flag, pend, grant;
  logic            master;
  logic            take;

  irq_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (ext_pin),
    .rise_en  (ext_rise_en),
    .fall_en  (ext_fall_en),
    .edge_evt (ext_evt)
  );

  assign evt_vec = {periph_req, ext_evt};

  irq_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we),
    .sel     (reg_sel),
    .wdata   (reg_wdata),
    .evt     (evt_vec),
    .take    (take),
    .grant   (grant),
    .reti_en (reti_en),
    .en      (en),
    .flag    (flag),
    .master  (master),
    .rdata   (reg_rdata)
  );

  assign pend = en & flag;

  irq_prio_pick #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_pick (
    .pend  (pend),
    .grant (grant),
    .vec   (irq_vec)
  );

  assign irq_req = master & (|pend) & ~stack_full;
  assign take    = irq_ack & irq_req;
  assign wake    = |flag;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            irq_req,
  input logic            stack_full,
  input logic            reg_we,
  input logic            reti_en,
  input logic            wake,
  input logic            master,
  input logic            take,
  input logic [NSRC-1:0] flag,
  input logic [NSRC-1:0] grant,
  input logic [NSRC-1:0] evt_vec
);
  assert_full_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stack_full |-> !irq_req);

  assert_req_needs_master_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> master);

  assert_entry_clears_master_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !master);

  assert_flag_served_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !reg_we && !(|evt_vec)) |=> ((flag & $past(grant)) == '0));

  assert_reti_sets_master_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_en && !take) |=> master);

  assert_single_winner_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ($countones(grant) == 1));

  assert_event_wakes_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_vec) |=> wake);
endmodule

bind irq_ctrl irq_ctrl_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_req    (irq_req),
  .stack_full (stack_full),
  .reg_we     (reg_we),
  .reti_en    (reti_en),
  .wake       (wake),
  .master     (master),
  .take       (take),
  .flag       (flag),
  .grant      (grant),
  .evt_vec    (evt_vec)
);

// File: tb/test_irq_ctrl.sv
`timescale 1ns/1ps
module test_irq_ctrl;
  localparam int WD_CYCLES = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_pin = 1'b0, ext_rise_en = 1'b0, ext_fall_en = 1'b0;
  logic [3:0] periph_req = '0;
  logic       reg_we = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       stack_full = 1'b0, irq_ack = 1'b0, reti_en = 1'b0;
  logic       irq_req, wake;
  logic [7:0] irq_vec;

  irq_ctrl i_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_rise_en(ext_rise_en),
    .ext_fall_en(ext_fall_en), .periph_req(periph_req), .reg_we(reg_we),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .stack_full(stack_full), .irq_ack(irq_ack), .reti_en(reti_en),
    .irq_req(irq_req), .irq_vec(irq_vec), .wake(wake)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string phase = "R13";

  // behavioural reference state
  bit       m_me;
  bit [4:0] m_en, m_fl;
  bit       hist[$];

  function automatic int winner(input bit [4:0] p);
    for (int i = 0; i < 5; i++) if (p[i]) return i;
    return -1;
  endfunction

  function automatic bit exp_req();
    return m_me && ((m_en & m_fl) != 0) && !stack_full;
  endfunction

  function automatic bit [7:0] exp_vec();
    int w = winner(m_en & m_fl);
    return (w < 0) ? 8'h00 : 8'(4 + 4 * w);
  endfunction

  function automatic bit [7:0] exp_rd();
    if (reg_sel == 1'b0) return {1'b0, m_fl[2:0], m_en[2:0], m_me};
    return {2'b00, m_fl[4:3], 2'b00, m_en[4:3]};
  endfunction

  task automatic chk(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s [%s] %s: actual %0h expected %0h at %0t", req, phase, what, got, exp, $time);
    end
  endtask

  task automatic compare();
    chk(reg_sel ? "R3" : "R2", "reg_rdata", int'(reg_rdata), int'(exp_rd()));
    chk("R4", "irq_req", int'(irq_req), int'(exp_req()));
    chk("R1", "irq_vec", int'(irq_vec), int'(exp_vec()));
    chk("R11", "wake", int'(wake), int'(m_fl != 0));
  endtask

  task automatic model_edge();
    bit [4:0] nf, ne, evs;
    bit nm, tk, ev_ext;
    int w;
    if (!rst_n) begin
      m_me = 0; m_en = '0; m_fl = '0;
      hist = '{0, 0, 0};
      return;
    end
    w  = winner(m_en & m_fl);
    tk = irq_ack && exp_req();
    ev_ext = (hist[1] && !hist[2] && ext_rise_en) || (!hist[1] && hist[2] && ext_fall_en);
    evs = {periph_req, ev_ext};
    nf = m_fl; ne = m_en; nm = m_me;
    if (reg_we && !reg_sel) begin nm = reg_wdata[0]; ne[2:0] = reg_wdata[3:1]; nf[2:0] = reg_wdata[6:4]; end
    if (reg_we && reg_sel)  begin ne[4:3] = reg_wdata[1:0]; nf[4:3] = reg_wdata[5:4]; end
    if (reti_en) nm = 1;
    if (tk) begin nm = 0; nf[w] = 0; end
    nf = nf | evs;
    m_fl = nf; m_en = ne; m_me = nm;
    hist.push_front(ext_pin);
    void'(hist.pop_back());
  endtask

  task automatic tick();
    #1 compare();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle();
    reg_we = 0; irq_ack = 0; reti_en = 0; periph_req = '0;
  endtask

  task automatic wr(input bit sel, input bit [7:0] d);
    reg_we = 1; reg_sel = sel; reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(WD_CYCLES * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    hist = '{0, 0, 0};
    @(negedge clk);
    phase = "R13"; ticks(3);
    rst_n = 1; tick();

    phase = "R2"; wr(0, 8'h8E); tick();
    phase = "R3"; wr(1, 8'hFF); tick(); reg_sel = 1; tick(); wr(1, 8'h03); tick();

    phase = "R7"; periph_req = 4'b0011; tick(); idle(); ticks(2);
    phase = "R4"; wr(0, 8'h6F); tick();
    phase = "R6"; irq_ack = 1; tick(); idle(); tick();
    phase = "R9"; reti_en = 1; tick(); idle(); tick(); irq_ack = 1; tick(); idle(); tick();

    phase = "R5"; periph_req = 4'b1000; tick(); idle();
    reti_en = 1; tick(); reti_en = 0;
    stack_full = 1; tick(); irq_ack = 1; tick(); irq_ack = 0; tick();
    stack_full = 0; tick(); irq_ack = 1; tick(); idle(); tick();

    phase = "R8"; wr(0, 8'h01); periph_req = 4'b0100; tick(); idle(); tick();
    irq_ack = 1; tick(); idle(); wr(0, 8'h01); tick();

    phase = "R10"; wr(0, 8'h03); ext_rise_en = 1;
    ext_pin = 1; ticks(5); irq_ack = 1; tick(); irq_ack = 0;
    ext_pin = 0; ticks(5);
    ext_rise_en = 0; ext_fall_en = 1; reti_en = 1; tick(); reti_en = 0;
    ext_pin = 1; ticks(4); ext_pin = 0; ticks(4); irq_ack = 1; tick(); irq_ack = 0;
    ext_rise_en = 1; reti_en = 1; tick(); reti_en = 0;
    ext_pin = 1; tick(); ext_pin = 0; ticks(3); irq_ack = 1; tick(); irq_ack = 0; ticks(2);

    phase = "R12"; wr(0, 8'h01); wr(1, 8'h03);
    periph_req = 4'b0100; tick(); idle(); tick();
    irq_ack = 1; periph_req = 4'b0100; tick(); idle(); tick();
    reg_we = 1; reg_sel = 1; reg_wdata = 8'h03; periph_req = 4'b1000; tick(); idle(); tick();
    reti_en = 1; irq_ack = 1; tick(); idle(); tick();

    phase = "R1"; wr(0, 8'h7F); wr(1, 8'h33); tick();
    for (int k = 0; k < 5; k++) begin
      irq_ack = 1; tick(); irq_ack = 0; reti_en = 1; tick(); reti_en = 0;
    end
    tick();

    for (int k = 0; k < 3000; k++) begin
      reg_we     = (($urandom % 12) == 0);
      reg_sel    = $urandom % 2;
      reg_wdata  = 8'($urandom);
      irq_ack    = (($urandom % 3) == 0);
      reti_en    = (($urandom % 6) == 0);
      stack_full = (($urandom % 4) == 0);
      for (int b = 0; b < 4; b++) periph_req[b] = (($urandom % 8) == 0);
      if (($urandom % 5) == 0) ext_pin = ~ext_pin;
      if (($urandom % 40) == 0) begin ext_rise_en = $urandom % 2; ext_fall_en = $urandom % 2; end
      tick();
    end
    idle(); stack_full = 0; tick();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule